// File: doc/BRIEF.md
# Split-Phase SCL Clock Divider

This block produces the serial clock timing for a two-wire bus master. A 32-bit divider value carries two independent 16-bit counts, one for the low part of the SCL period and one for the high part, so the duty cycle can be tuned as well as the rate. Each phase is cut into eight equal slices of (count + 1) system clocks. A phase therefore lasts eight times its count plus one, and a full period lasts 8 × (low count + high count + 2) system clocks.

The transfer engine drives a single run input. While it is low, SCL rests high and no strobes appear. When it rises, a period begins with a low phase. When it falls, the period in progress is finished before SCL comes to rest high. Besides the SCL level, the block gives the engine one-cycle strobes: one at each phase edge, one in the middle of the low phase where SDA may change, one in the middle of the high phase where SDA is sampled, and a tick at every quarter of each phase. A divider write is stored at once and read back directly. The counts in use are only replaced when a new period starts, so a period is never stretched or cut short halfway.

Top module: `scl_split_divider`

## Requirements
- R1: After reset the stored divider value is zero. A write stores all 32 bits, and the value appears on `div_value` on the cycle after the write.
- R2: The low phase lasts 8 × (L + 1) clock cycles, where L is bits 15:0 of the divider value in use.
- R3: The high phase lasts 8 × (H + 1) clock cycles, where H is bits 31:16 of the divider value in use.
- R4: The distance between successive falling edges while running is 8 × (L + H + 2) cycles. With L = H = 0 this is 16 cycles. With L and H one apart, the phases differ by 8 cycles.
- R5: While idle (after reset, or after a stop), `scl_o` is 1 and every strobe output is 0.
- R6: If `run_en` is 1 on an idle clock edge, then after that edge `scl_o` is 0 with `fall_stb` set. If `run_en` is 0 at the end of a high phase, SCL stays high and no new period starts. A drop of `run_en` earlier than that does not shorten the period.
- R7: The counts in use are taken from the stored divider value only at the start of a period. A write during a period does not change that period.
- R8: `fall_stb` is 1 only in the first cycle of a low phase, and `rise_stb` only in the first cycle of a high phase.
- R9: `mid_low_stb` is 1 only at cycle 4 × (L + 1) of a low phase, and `mid_high_stb` only at cycle 4 × (H + 1) of a high phase. Cycles are counted from 0 at the phase edge.
- R10: `quarter_tick` is 1 at cycles 0, 2(N+1), 4(N+1) and 6(N+1) of each phase, where N is that phase's count, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Engine request to generate SCL periods |
| div_wr | input | 1 | Store `div_wdata` as the divider value |
| div_wdata | input | 32 | Divider value: high count in bits 31:16, low count in bits 15:0 |
| div_value | output | 32 | Stored divider value |
| scl_o | output | 1 | SCL level, 1 when idle |
| fall_stb | output | 1 | First cycle of a low phase |
| rise_stb | output | 1 | First cycle of a high phase |
| mid_low_stb | output | 1 | Middle of the low phase (SDA change point) |
| mid_high_stb | output | 1 | Middle of the high phase (SDA sample point) |
| quarter_tick | output | 1 | Start of each quarter of a phase |

## Verification
The assertions check on every cycle the properties that hold at any moment. The strobes never overlap, and each edge strobe matches the SCL level it announces. A fall only follows a high level. Idle means SCL high with cleared slice state. The counts in use hold still between period starts. The durations of the phases, the placement of the midpoint and quarter strobes, the effect of a write made during a period, and the way a stop request completes the current period can only be shown by the bench. It drives random and directed divider values and run patterns, and compares each output on every cycle with a cycle model built from the requirements.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;

  // each phase is cut into this many equal slices of (count+1) cycles
  localparam int unsigned SLICES     = 8;
  localparam int unsigned SLICE_W    = $clog2(SLICES);
  localparam int unsigned SLICE_LAST = SLICES - 1;
  localparam int unsigned SLICE_MID  = SLICES / 2;
endpackage

// File: rtl/scl_div_cfg.sv
module scl_div_cfg #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DIV_W = 2 * CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [DIV_W-1:0] wr_data,
  input  logic             load,
  output logic [DIV_W-1:0] div_q,
  output logic [CNT_W-1:0] lo_cnt,
  output logic [CNT_W-1:0] hi_cnt
);
  // stored value is visible at once; counts in use follow it only on load
  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      lo_cnt <= '0;
      hi_cnt <= '0;
    end else begin
      if (wr_en) div_q <= wr_data;
      if (load) begin
        lo_cnt <= div_q[CNT_W-1:0];
        hi_cnt <= div_q[DIV_W-1:CNT_W];
      end
    end
  end

  AST_COUNTS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(lo_cnt) && $stable(hi_cnt))); // R7

  AST_WRITE_STORED: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (div_q == $past(wr_data))); // R1
endmodule

// File: rtl/scl_div_timer.sv
module scl_div_timer
  import scl_div_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run_en,
  input  logic [CNT_W-1:0]   lo_cnt,
  input  logic [CNT_W-1:0]   hi_cnt,
  output scl_phase_e         phase,
  output logic               load,
  output scl_phase_e         nxt_phase,
  output logic               nxt_sub_zero,
  output logic [SLICE_W-1:0] nxt_slice
);
  logic [CNT_W-1:0]   sub;
  logic [SLICE_W-1:0] slice;
  logic [CNT_W-1:0]   cur_n;
  logic [CNT_W-1:0]   nxt_sub;
  logic               slice_end;
  logic               phase_end;

  assign cur_n     = (phase == PH_HIGH) ? hi_cnt : lo_cnt;
  assign slice_end = (sub == cur_n);
  assign phase_end = slice_end && (slice == SLICE_W'(SLICE_LAST));
  // a period starts from idle, or when a high phase ends while running
  assign load      = run_en && ((phase == PH_IDLE) || ((phase == PH_HIGH) && phase_end));

  always_comb begin
    nxt_phase = phase;
    nxt_sub   = sub;
    nxt_slice = slice;
    case (phase)
      PH_IDLE: begin
        nxt_sub   = '0;
        nxt_slice = '0;
        if (run_en) nxt_phase = PH_LOW;
      end
      PH_LOW, PH_HIGH: begin
        if (slice_end) begin
          nxt_sub   = '0;
          nxt_slice = slice + SLICE_W'(1);
          if (phase_end) begin
            if (phase == PH_LOW)  nxt_phase = PH_HIGH;
            else if (run_en)      nxt_phase = PH_LOW;
            else                  nxt_phase = PH_IDLE;
          end
        end else begin
          nxt_sub = sub + CNT_W'(1);
        end
      end
      default: begin
        nxt_phase = PH_IDLE;
        nxt_sub   = '0;
        nxt_slice = '0;
      end
    endcase
  end

  assign nxt_sub_zero = (nxt_sub == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      sub   <= '0;
      slice <= '0;
    end else begin
      phase <= nxt_phase;
      sub   <= nxt_sub;
      slice <= nxt_slice;
    end
  end

  AST_SUB_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE) |-> (sub <= cur_n)); // R2 R3

  AST_IDLE_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE) |-> ((sub == '0) && (slice == '0))); // R5
endmodule

// File: rtl/scl_div_strobe.sv
module scl_div_strobe
  import scl_div_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  scl_phase_e         nxt_phase,
  input  logic               nxt_sub_zero,
  input  logic [SLICE_W-1:0] nxt_slice,
  output logic               scl_o,
  output logic               fall_stb,
  output logic               rise_stb,
  output logic               mid_low_stb,
  output logic               mid_high_stb,
  output logic               quarter_tick
);
  logic slice_start;
  logic in_low;
  logic in_high;

  assign slice_start = nxt_sub_zero;
  assign in_low      = (nxt_phase == PH_LOW);
  assign in_high     = (nxt_phase == PH_HIGH);

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_o        <= 1'b1;
      fall_stb     <= 1'b0;
      rise_stb     <= 1'b0;
      mid_low_stb  <= 1'b0;
      mid_high_stb <= 1'b0;
      quarter_tick <= 1'b0;
    end else begin
      scl_o        <= !in_low;
      fall_stb     <= in_low  && slice_start && (nxt_slice == '0);
      rise_stb     <= in_high && slice_start && (nxt_slice == '0);
      mid_low_stb  <= in_low  && slice_start && (nxt_slice == SLICE_W'(SLICE_MID));
      mid_high_stb <= in_high && slice_start && (nxt_slice == SLICE_W'(SLICE_MID));
      quarter_tick <= (in_low || in_high) && slice_start && !nxt_slice[0];
    end
  end

  AST_STROBES_APART: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fall_stb, rise_stb, mid_low_stb, mid_high_stb})); // R8

  AST_FALL_LOW: assert property (@(posedge clk) disable iff (rst)
    fall_stb |-> !scl_o); // R8

  AST_RISE_HIGH: assert property (@(posedge clk) disable iff (rst)
    rise_stb |-> scl_o); // R8

  AST_FALL_AFTER_HIGH: assert property (@(posedge clk) disable iff (rst)
    fall_stb |-> $past(scl_o)); // R6

  AST_MID_LEVELS: assert property (@(posedge clk) disable iff (rst)
    (mid_low_stb |-> !scl_o) and (mid_high_stb |-> scl_o)); // R9
endmodule

// File: rtl/scl_split_divider.sv
module scl_split_divider
  import scl_div_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  localparam int unsigned DIV_W = 2 * CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_wdata,
  output logic [DIV_W-1:0] div_value,
  output logic             scl_o,
  output logic             fall_stb,
  output logic             rise_stb,
  output logic             mid_low_stb,
  output logic             mid_high_stb,
  output logic             quarter_tick
);
  logic [CNT_W-1:0]   lo_cnt;
  logic [CNT_W-1:0]   hi_cnt;
  logic               load;
  scl_phase_e         phase;
  scl_phase_e         nxt_phase;
  logic               nxt_sub_zero;
  logic [SLICE_W-1:0] nxt_slice;

  scl_div_cfg #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (div_wr),
    .wr_data (div_wdata),
    .load    (load),
    .div_q   (div_value),
    .lo_cnt  (lo_cnt),
    .hi_cnt  (hi_cnt)
  );

  scl_div_timer #(.CNT_W(CNT_W)) u_timer (
    .clk          (clk),
    .rst          (rst),
    .run_en       (run_en),
    .lo_cnt       (lo_cnt),
    .hi_cnt       (hi_cnt),
    .phase        (phase),
    .load         (load),
    .nxt_phase    (nxt_phase),
    .nxt_sub_zero (nxt_sub_zero),
    .nxt_slice    (nxt_slice)
  );

  scl_div_strobe u_strobe (
    .clk          (clk),
    .rst          (rst),
    .nxt_phase    (nxt_phase),
    .nxt_sub_zero (nxt_sub_zero),
    .nxt_slice    (nxt_slice),
    .scl_o        (scl_o),
    .fall_stb     (fall_stb),
    .rise_stb     (rise_stb),
    .mid_low_stb  (mid_low_stb),
    .mid_high_stb (mid_high_stb),
    .quarter_tick (quarter_tick)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE) |-> (scl_o && !quarter_tick && !fall_stb && !rise_stb)); // R5
endmodule

// File: tb/scl_split_divider_bench.sv
module scl_split_divider_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_en = 1'b0;
  logic        div_wr = 1'b0;
  logic [31:0] div_wdata = '0;
  logic [31:0] div_value;
  logic        scl_o, fall_stb, rise_stb, mid_low_stb, mid_high_stb, quarter_tick;

  always #10 clk = ~clk; // 50 MHz

  scl_split_divider u_scl_split_divider (
    .clk(clk), .rst(rst), .run_en(run_en), .div_wr(div_wr), .div_wdata(div_wdata),
    .div_value(div_value), .scl_o(scl_o), .fall_stb(fall_stb), .rise_stb(rise_stb),
    .mid_low_stb(mid_low_stb), .mid_high_stb(mid_high_stb), .quarter_tick(quarter_tick)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int phase_len(input int n);
    return 8 * (n + 1);
  endfunction

  function automatic int period_len(input int lo, input int hi);
    return 8 * (lo + hi + 2);
  endfunction

  // cycle model built from the requirements: 0 idle, 1 low, 2 high
  int m_ph = 0, m_pos = 0, m_lo = 0, m_hi = 0;
  logic [31:0] m_div = '0;
  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_pos = 0; m_lo = 0; m_hi = 0; m_div = '0;
    end else begin
      case (m_ph)
        0: if (run_en) begin
             m_ph = 1; m_pos = 0; m_lo = int'(m_div[15:0]); m_hi = int'(m_div[31:16]);
           end
        1: if (m_pos == phase_len(m_lo) - 1) begin m_ph = 2; m_pos = 0; end
           else m_pos++;
        default: if (m_pos == phase_len(m_hi) - 1) begin
             if (run_en) begin
               m_ph = 1; m_pos = 0; m_lo = int'(m_div[15:0]); m_hi = int'(m_div[31:16]);
             end else begin
               m_ph = 0; m_pos = 0;
             end
           end else m_pos++;
      endcase
      if (div_wr) m_div = div_wdata;
    end
  end

  // per-cycle comparison and period measurement, away from the active edge
  longint cyc = 0, prev_fall = 0;
  int prev_period = 0;
  bit prev_ok = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (!rst && !done) begin
      int n, q;
      n = (m_ph == 2) ? m_hi : m_lo;
      q = 2 * (n + 1);
      chk("R1 div_value", div_value, m_div);
      chk("R5 scl_o", scl_o, (m_ph != 1));
      chk("R8 fall_stb", fall_stb, (m_ph == 1 && m_pos == 0));
      chk("R8 rise_stb", rise_stb, (m_ph == 2 && m_pos == 0));
      chk("R9 mid_low_stb", mid_low_stb, (m_ph == 1 && m_pos == 4 * (m_lo + 1)));
      chk("R9 mid_high_stb", mid_high_stb, (m_ph == 2 && m_pos == 4 * (m_hi + 1)));
      chk("R10 quarter_tick", quarter_tick, (m_ph != 0 && (m_pos % q) == 0));
      if (m_ph == 0) prev_ok = 1'b0;
      if (fall_stb) begin
        if (prev_ok) chk("R4 period", cyc - prev_fall, prev_period);
        prev_ok = 1'b1;
        prev_fall = cyc;
        prev_period = period_len(m_lo, m_hi);
      end
    end
  end

  task automatic write_div(input int lo, input int hi);
    div_wdata = {hi[15:0], lo[15:0]};
    div_wr = 1'b1;
    @(negedge clk);
    div_wr = 1'b0;
  endtask

  task automatic wait_idle();
    run_en = 1'b0;
    while (m_ph != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // R2 R3 R4: measure one period directly from the strobes
  task automatic measure(input int lo, input int hi);
    int lcnt, hcnt;
    wait_idle();
    write_div(lo, hi);
    run_en = 1'b1;
    while (!fall_stb) @(negedge clk);
    lcnt = 0;
    do begin @(negedge clk); lcnt++; end while (!rise_stb);
    hcnt = 0;
    do begin @(negedge clk); hcnt++; end while (!fall_stb);
    chk("R2 low length", lcnt, phase_len(lo));
    chk("R3 high length", hcnt, phase_len(hi));
    chk("R4 total", lcnt + hcnt, period_len(lo, hi));
    wait_idle();
  endtask

  initial begin
    int cnt;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset div_value", div_value, 0);
    chk("R5 reset scl_o", scl_o, 1);
    chk("R5 reset strobes", {fall_stb, rise_stb, mid_low_stb, mid_high_stb, quarter_tick}, 0);

    // R1: full-width write readback while idle, then replaced before any run
    write_div(16'h1234, 16'hFEDC);
    chk("R1 readback", div_value, 32'hFEDC1234);

    measure(0, 0);   // fastest: 16
    measure(1, 0);   // odd divisor, phases differ by 8
    measure(0, 1);
    measure(3, 5);

    // R6: start from idle gives fall right after the edge
    wait_idle();
    write_div(2, 1);
    run_en = 1'b1;
    @(negedge clk);
    chk("R6 start scl low", scl_o, 0);
    chk("R6 start fall", fall_stb, 1);
    // R6: drop request early, the period still completes then SCL rests
    run_en = 1'b0;
    cnt = 1;
    while (!rise_stb) begin @(negedge clk); cnt++; end
    chk("R6 low completes", cnt, phase_len(2) + 1);
    cnt = 0;
    repeat (phase_len(1) + 40) begin
      @(negedge clk);
      if (!scl_o || fall_stb) cnt++;
    end
    chk("R6 stays high after stop", cnt, 0);

    // R7: write during a period leaves that period untouched
    wait_idle();
    write_div(0, 0);
    run_en = 1'b1;
    while (!fall_stb) @(negedge clk);
    write_div(2, 2);
    cnt = 1;
    while (!rise_stb) begin @(negedge clk); cnt++; end
    chk("R7 current low unchanged", cnt, phase_len(0));
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!fall_stb);
    chk("R7 current high unchanged", cnt, phase_len(0));
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!rise_stb);
    chk("R7 next low uses new value", cnt, phase_len(2));
    wait_idle();

    // random mix; the cycle model checks every output each cycle
    for (int it = 0; it < 60; it++) begin
      int lo, hi;
      lo = int'($urandom_range(0, 6));
      hi = int'($urandom_range(0, 6));
      repeat ($urandom_range(0, 20)) @(negedge clk);
      write_div(lo, hi);
      run_en = ($urandom_range(0, 3) != 0);
      repeat ($urandom_range(10, 250)) @(negedge clk);
    end
    wait_idle();
    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule